// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is the sum-of-products core of a small programmable logic device, with its whole configuration held in on-chip registers. A vector of array inputs (device pins plus register feedbacks) reaches every product term in both true and complement form. Each product term is the AND of the literals its select bits enable. Groups of product terms are ORed into sum terms, two per output cell. The remaining product terms drive the cell controls: one output enable per cell, one clock term and one asynchronous-reset term per register, and a single synchronous-preset term shared by all registers.

The number of product terms in each sum term is fixed. Sum term k receives 4 + (k mod 5) terms, so the counts run 4, 5, 6, 7, 8 and repeat. With 42 inputs and 10 cells this gives 120 sum-term products and 51 control products, 171 in all. The defaults are a reduced 12-input, 4-cell instance with 66 product terms.

Configuration travels through a serial chain clocked by the system clock. Loading it into the array, capturing the array back for verify, and a full erase are sequenced by a small state machine. Its states are IDLE, SHIFT, LOAD, CAPT and ERASE. IDLE and SHIFT accept commands in priority order erase, load, capture, shift, and move to SHIFT while shifting and to IDLE when no command is present. LOAD, CAPT and ERASE each last one cycle and always return to IDLE. Commands presented during those three states are ignored. A security bit at the top of the chain masks readback.

Top module: `pla_array`

## Requirements
- R1: After reset all array outputs are 0 and `cfg_dout` is 0.
- R2: A product term with no select bit set evaluates to 0, so an unconfigured array drives every output to 0 whatever the inputs.
- R3: Chain bit `t*2*N_IN + 2*i` selects input i in true form for product term t, and bit `t*2*N_IN + 2*i + 1` selects its complement. A term is 1 only when every selected literal is 1, so selecting both forms of one input makes the term 0.
- R4: Sum term k is the OR of product terms `off(k)` to `off(k)+4+(k mod 5)-1`, where `off(k)` is the total count of terms in sum terms 0 to k-1.
- R5: After the sum-term products, the next product terms are, in order: the output enables of cells 0 upward, the register clock terms, the register reset terms, and the shared preset term.
- R6: Shifting has no effect on the outputs. A load strobe sampled at one clock edge puts IDLE to LOAD. The chain contents then reach the array at the following edge, and the array holds them until the next load or erase.
- R7: A capture strobe moves IDLE to CAPT. At the following edge the chain is filled with the array configuration plus the security bit. Shifting then presents chain bit j on `cfg_dout` before the j-th shift, starting at bit 0. Bits enter at the top of the chain.
- R8: The security bit is chain bit `N_PT*2*N_IN`. When the loaded security bit is 1, a capture returns 1 in every chain position, including on the first capture after the load that set it. The array keeps working with its real configuration.
- R9: An erase strobe moves IDLE to ERASE. At the next edge it clears the array configuration, the security bit and the chain, after which all outputs are 0 and a capture returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arr_in | input | N_IN | Array inputs (pins and feedbacks) |
| cfg_shift | input | 1 | Shift the chain one place |
| cfg_din | input | 1 | Serial data entering the top of the chain |
| cfg_load | input | 1 | Load strobe: chain to array |
| cfg_capture | input | 1 | Verify strobe: array to chain |
| cfg_erase | input | 1 | Full erase strobe |
| cfg_dout | output | 1 | Serial data leaving the bottom of the chain |
| sum_o | output | 2*N_CELLS | Sum-term outputs |
| oe_o | output | N_CELLS | Output-enable product terms |
| rclk_o | output | 2*N_CELLS | Register clock product terms |
| rrst_o | output | 2*N_CELLS | Register asynchronous-reset product terms |
| preset_o | output | 1 | Shared synchronous-preset product term |

## Verification
A corrupted bit in the loaded configuration shows up combinationally on the output of the term that owns it, as soon as the bench drives an input pattern that sensitises that literal. The one-hot input sweeps place one literal per sum term and one per control term to make this happen. A fault in the chain or in the load timing appears either one cycle early or late on the outputs around a load, or as a mismatch in the full-chain readback. A stuck security bit is visible on the very first captured bit.

// File: rtl/pla_pkg.sv
package pla_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOAD,
        ST_CAPT,
        ST_ERASE
    } cfg_state_e;

    // product terms feeding sum term k: 4,5,6,7,8 repeating
    function automatic int sum_cnt(input int k);
        return 4 + (k % 5);
    endfunction

    // first product term index of sum term k
    function automatic int sum_off(input int k);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += sum_cnt(j);
        end
        return acc;
    endfunction

endpackage

// File: rtl/pla_pterm.sv
module pla_pterm #(
    parameter int N_IN = 12
) (
    input  logic [N_IN-1:0]   x,
    input  logic [2*N_IN-1:0] sel,
    output logic              pt
);
    logic [2*N_IN-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[2*i]   = x[i];
            lits[2*i+1] = ~x[i];
        end
    end

    // empty term is forced low
    assign pt = (|sel) & (&(lits | ~sel));
endmodule

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int CFG_BITS = 1584
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift,
    input  logic                din,
    input  logic                load,
    input  logic                capture,
    input  logic                erase,
    output logic                dout,
    output logic [CFG_BITS-1:0] active_o,
    output logic                sec_o,
    output pla_pkg::cfg_state_e state_o
);
    import pla_pkg::*;

    localparam int CHAIN = CFG_BITS + 1;

    cfg_state_e         cur_st, nxt_st;
    logic [CHAIN-1:0]   shadow;
    logic [CFG_BITS-1:0] active;
    logic               sec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_st <= ST_IDLE;
        else        cur_st <= nxt_st;
    end

    // next state
    always_comb begin
        nxt_st = ST_IDLE;
        unique case (cur_st)
            ST_IDLE, ST_SHIFT: begin
                if (erase)        nxt_st = ST_ERASE;
                else if (load)    nxt_st = ST_LOAD;
                else if (capture) nxt_st = ST_CAPT;
                else if (shift)   nxt_st = ST_SHIFT;
                else              nxt_st = ST_IDLE;
            end
            ST_LOAD, ST_CAPT, ST_ERASE: nxt_st = ST_IDLE;
            default:                    nxt_st = ST_IDLE;
        endcase
    end

    // storage actions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= '0;
            active <= '0;
            sec    <= 1'b0;
        end else begin
            unique case (cur_st)
                ST_IDLE, ST_SHIFT: begin
                    if (nxt_st == ST_SHIFT) shadow <= {din, shadow[CHAIN-1:1]};
                end
                ST_LOAD: begin
                    active <= shadow[CFG_BITS-1:0];
                    sec    <= shadow[CFG_BITS];
                end
                ST_CAPT: begin
                    if (sec) shadow <= '1;
                    else     shadow <= {sec, active};
                end
                ST_ERASE: begin
                    shadow <= '0;
                    active <= '0;
                    sec    <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        dout     = shadow[0];
        active_o = active;
        sec_o    = sec;
        state_o  = cur_st;
    end
endmodule

// File: rtl/pla_array.sv
module pla_array #(
    parameter int N_IN    = 12,
    parameter int N_CELLS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IN-1:0]      arr_in,
    input  logic                 cfg_shift,
    input  logic                 cfg_din,
    input  logic                 cfg_load,
    input  logic                 cfg_capture,
    input  logic                 cfg_erase,
    output logic                 cfg_dout,
    output logic [2*N_CELLS-1:0] sum_o,
    output logic [N_CELLS-1:0]   oe_o,
    output logic [2*N_CELLS-1:0] rclk_o,
    output logic [2*N_CELLS-1:0] rrst_o,
    output logic                 preset_o
);
    localparam int N_SUM    = 2 * N_CELLS;
    localparam int SUM_PT   = pla_pkg::sum_off(N_SUM);
    localparam int OE_BASE  = SUM_PT;
    localparam int CK_BASE  = OE_BASE + N_CELLS;
    localparam int RS_BASE  = CK_BASE + N_SUM;
    localparam int PR_BASE  = RS_BASE + N_SUM;
    localparam int N_PT     = PR_BASE + 1;
    localparam int W        = 2 * N_IN;
    localparam int CFG_BITS = N_PT * W;

    logic [CFG_BITS-1:0]  cfg_act;
    logic                 cfg_sec;
    pla_pkg::cfg_state_e  chain_st;
    logic [N_PT-1:0]      pt;

    pla_cfg_chain #(.CFG_BITS(CFG_BITS)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (cfg_shift),
        .din      (cfg_din),
        .load     (cfg_load),
        .capture  (cfg_capture),
        .erase    (cfg_erase),
        .dout     (cfg_dout),
        .active_o (cfg_act),
        .sec_o    (cfg_sec),
        .state_o  (chain_st)
    );

    for (genvar t = 0; t < N_PT; t++) begin : g_pt
        pla_pterm #(.N_IN(N_IN)) u_pt (
            .x   (arr_in),
            .sel (cfg_act[t*W +: W]),
            .pt  (pt[t])
        );
    end

    for (genvar k = 0; k < N_SUM; k++) begin : g_sum
        localparam int OFF = pla_pkg::sum_off(k);
        localparam int CNT = pla_pkg::sum_cnt(k);
        assign sum_o[k] = |pt[OFF +: CNT];
    end

    assign oe_o     = pt[OE_BASE +: N_CELLS];
    assign rclk_o   = pt[CK_BASE +: N_SUM];
    assign rrst_o   = pt[RS_BASE +: N_SUM];
    assign preset_o = pt[PR_BASE];
endmodule

// File: rtl/pla_array_chk.sv
module pla_array_chk #(
    parameter int N_IN     = 12,
    parameter int N_CELLS  = 4,
    parameter int CFG_BITS = 1584
) (
    input logic                 clk,
    input logic                 rst_n,
    input pla_pkg::cfg_state_e  state,
    input logic [CFG_BITS-1:0]  active,
    input logic                 sec,
    input logic                 dout,
    input logic [N_IN-1:0]      arr_in,
    input logic [2*N_CELLS-1:0] sum_o,
    input logic [N_CELLS-1:0]   oe_o,
    input logic [2*N_CELLS-1:0] rclk_o,
    input logic [2*N_CELLS-1:0] rrst_o,
    input logic                 preset_o
);
    import pla_pkg::*;

    // R2: empty array drives nothing, for any input
    a_r2_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0 && $stable(arr_in)) |->
        (sum_o == '0 && oe_o == '0 && rclk_o == '0 && rrst_o == '0 && !preset_o));

    // R6: array only changes through LOAD or ERASE
    a_r6_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LOAD && state != ST_ERASE) |=> $stable(active));

    // R6: LOAD lasts one cycle
    a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_IDLE));

    // R8: secured capture reads ones
    a_r8_secure_read: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPT && sec) |=> dout);

    // R9: erase clears everything
    a_r9_erase_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE) |=> (active == '0 && !sec && !dout));
endmodule

bind pla_array pla_array_chk #(
    .N_IN     (N_IN),
    .N_CELLS  (N_CELLS),
    .CFG_BITS (CFG_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (chain_st),
    .active   (cfg_act),
    .sec      (cfg_sec),
    .dout     (cfg_dout),
    .arr_in   (arr_in),
    .sum_o    (sum_o),
    .oe_o     (oe_o),
    .rclk_o   (rclk_o),
    .rrst_o   (rrst_o),
    .preset_o (preset_o)
);

// File: tb/test_pla_array.sv
module test_pla_array;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN  = 12;
    localparam int N_CELLS = 4;
    localparam int N_SUM = 8;
    localparam int W     = 2 * N_IN;
    localparam int OEB   = 45;   // 4+5+6+7+8+4+5+6
    localparam int CKB   = OEB + N_CELLS;
    localparam int RSB   = CKB + N_SUM;
    localparam int PRB   = RSB + N_SUM;
    localparam int NPT   = PRB + 1;
    localparam int CB    = NPT * W;
    localparam int CH    = CB + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0] arr_in = '0;
    logic cfg_shift = 1'b0, cfg_din = 1'b0, cfg_load = 1'b0;
    logic cfg_capture = 1'b0, cfg_erase = 1'b0;
    logic cfg_dout;
    logic [N_SUM-1:0] sum_o, rclk_o, rrst_o;
    logic [N_CELLS-1:0] oe_o;
    logic preset_o;

    int checks = 0;
    int errors = 0;
    logic [CH-1:0] mv;
    logic [CH-1:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;

    pla_array #(.N_IN(N_IN), .N_CELLS(N_CELLS)) i_pla_array (
        .clk(clk), .rst_n(rst_n), .arr_in(arr_in),
        .cfg_shift(cfg_shift), .cfg_din(cfg_din), .cfg_load(cfg_load),
        .cfg_capture(cfg_capture), .cfg_erase(cfg_erase), .cfg_dout(cfg_dout),
        .sum_o(sum_o), .oe_o(oe_o), .rclk_o(rclk_o), .rrst_o(rrst_o),
        .preset_o(preset_o)
    );

    function automatic int b_off(input int k);
        int a = 0;
        for (int j = 0; j < k; j++) a += 4 + (j % 5);
        return a;
    endfunction

    function automatic int b_cnt(input int k);
        return 4 + (k % 5);
    endfunction

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_lit(input int term, input int inp, input bit comp);
        mv[term*W + 2*inp + int'(comp)] = 1'b1;
    endtask

    task automatic shift_vec(input logic [CH-1:0] v);
        for (int j = 0; j < CH; j++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_din   = v[j];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_din   = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk) cfg_load = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_back();
        @(negedge clk) cfg_capture = 1'b1;
        @(negedge clk) cfg_capture = 1'b0;
        @(negedge clk);
        for (int j = 0; j < CH; j++) begin
            got[j] = cfg_dout;
            cfg_shift = 1'b1;
            @(negedge clk);
        end
        cfg_shift = 1'b0;
    endtask

    task automatic drive(input logic [N_IN-1:0] v);
        arr_in = v;
        #1;
    endtask

    task automatic t_reset();
        check_eq("R1", "sum", 32'(sum_o), 0);
        check_eq("R1", "ctrl", {oe_o, rclk_o, rrst_o, preset_o}, 0);
        check_eq("R1", "dout", 32'(cfg_dout), 0);
    endtask

    task automatic t_empty();
        drive(12'hFFF);
        check_eq("R2", "all ones in", {sum_o, oe_o, rclk_o, rrst_o, preset_o}, 0);
        drive(12'h5A3);
        check_eq("R2", "mixed in", {sum_o, oe_o, rclk_o, rrst_o, preset_o}, 0);
    endtask

    task automatic t_literal();
        mv = '0;
        set_lit(0, 0, 0);
        set_lit(0, 1, 1);
        drive(12'h001);
        shift_vec(mv);
        #1 check_eq("R6", "shift only", 32'(sum_o), 0);
        @(negedge clk) cfg_load = 1'b1;
        @(negedge clk) cfg_load = 1'b0;
        #1 check_eq("R6", "in LOAD", 32'(sum_o), 0);
        @(negedge clk);
        #1 check_eq("R6", "after load", 32'(sum_o), 1);
        drive(12'h000); check_eq("R3", "x=00", 32'(sum_o[0]), 0);
        drive(12'h003); check_eq("R3", "x=11", 32'(sum_o[0]), 0);
        drive(12'h002); check_eq("R3", "x=10", 32'(sum_o[0]), 0);
        drive(12'hFFD); check_eq("R3", "others high", 32'(sum_o[0]), 1);
    endtask

    task automatic t_both_pol();
        mv = '0;
        set_lit(b_off(1), 2, 0);
        set_lit(b_off(1), 2, 1);
        set_lit(b_off(1) + 1, 3, 0);
        shift_vec(mv);
        pulse_load();
        drive(12'h004); check_eq("R3", "both pol x2=1", 32'(sum_o[1]), 0);
        drive(12'h000); check_eq("R3", "both pol x2=0", 32'(sum_o[1]), 0);
        drive(12'h008); check_eq("R3", "second term", 32'(sum_o[1]), 1);
    endtask

    task automatic t_alloc();
        mv = '0;
        for (int k = 0; k < N_SUM; k++) begin
            set_lit(b_off(k), k, 0);
            set_lit(b_off(k) + b_cnt(k) - 1, k, 0);
        end
        shift_vec(mv);
        pulse_load();
        for (int k = 0; k < N_SUM; k++) begin
            drive(12'(1 << k));
            check_eq("R4", $sformatf("sum %0d edges", k), 32'(sum_o), 32'(1 << k));
        end
    endtask

    task automatic build_ctrl();
        mv = '0;
        for (int c = 0; c < N_CELLS; c++) set_lit(OEB + c, c, 0);
        for (int r = 0; r < N_SUM; r++) begin
            set_lit(CKB + r, r, 0);
            set_lit(RSB + r, r, 1);
        end
        set_lit(PRB, N_IN - 1, 0);
    endtask

    task automatic t_ctrl();
        build_ctrl();
        shift_vec(mv);
        pulse_load();
        for (int k = 0; k < N_SUM; k++) begin
            drive(12'(1 << k));
            check_eq("R5", $sformatf("oe k=%0d", k), 32'(oe_o),
                     (k < N_CELLS) ? 32'(1 << k) : 0);
            check_eq("R5", $sformatf("clk/rst k=%0d", k), {rclk_o, rrst_o},
                     {8'(1 << k), ~8'(1 << k)});
            check_eq("R5", $sformatf("preset/sum k=%0d", k), {preset_o, sum_o}, 0);
        end
        drive(12'h800);
        check_eq("R5", "preset term", {preset_o, rclk_o, rrst_o, oe_o}, {1'b1, 8'h00, 8'hFF, 4'h0});
    endtask

    task automatic t_readback();
        int bad;
        read_back();
        bad = 0;
        for (int j = 0; j < CH; j++) if (got[j] !== mv[j]) bad++;
        check_eq("R7", "readback mismatches", bad, 0);
    endtask

    task automatic t_secure();
        int zeros;
        build_ctrl();
        mv[CB] = 1'b1;
        shift_vec(mv);
        pulse_load();
        read_back();
        zeros = 0;
        for (int j = 0; j < CH; j++) if (got[j] !== 1'b1) zeros++;
        check_eq("R8", "secured zeros read", zeros, 0);
        drive(12'h001);
        check_eq("R8", "array still live", 32'(rclk_o), 1);
    endtask

    task automatic t_erase();
        int ones;
        @(negedge clk) cfg_erase = 1'b1;
        @(negedge clk) cfg_erase = 1'b0;
        @(negedge clk);
        drive(12'h001);
        check_eq("R9", "outputs after erase", {sum_o, oe_o, rclk_o, rrst_o, preset_o}, 0);
        check_eq("R9", "dout after erase", 32'(cfg_dout), 0);
        read_back();
        ones = 0;
        for (int j = 0; j < CH; j++) if (got[j] !== 1'b0) ones++;
        check_eq("R9", "ones read after erase", ones, 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_empty();
        t_literal();
        t_both_pol();
        t_alloc();
        t_ctrl();
        t_readback();
        t_secure();
        t_erase();
        finish_run();
    end
endmodule